// File: doc/BRIEF.md
# Compact Accumulator Microcontroller Core

This block is a small 8-bit microcontroller core built around a single working register (W). It fetches one 12-bit instruction per clock from a 256-word program store outside the block. The core drives the store's address port and reads the word back combinationally in the same cycle. The core holds a register file of 24 general-purpose bytes, three 8-bit I/O ports and a two-level return stack. It runs a reduced instruction set: literal and register moves, clears, increment, add, AND, nibble swap, single-bit test-and-skip, absolute jump, subroutine call and return-with-literal, and a port-direction load.

Each port appears at the boundary as three separate vectors: pin input, output latch and output enable. No tristate pads are modelled. Every instruction takes one cycle. Any instruction that changes control flow adds one dead cycle, in which the program counter holds and the fetched word is not executed. The core is meant to be embedded in a larger design, with a ROM or a preloaded memory on the instruction port and board logic on the ports.

Top module: `mcu_core`

## Requirements
- R1: While rst_n is low, imem_addr is 0, every port output latch is 0x00 and every output enable is 0x00 (all pins inputs). rst_n is released through two synchronizing flops, so the word at address 0 executes on the third rising clock edge after rst_n goes high.
- R2: MOVLW (1100kkkkkkkk) loads the literal into W. MOVWF (0000001fffff) stores W into file address f. Port A, B and C sit at file addresses 0x05, 0x06 and 0x07. General-purpose registers occupy 0x08 to 0x1F.
- R3: MOVF (001000dfffff), INCF (001010dfffff), ADDWF (000111dfffff), ANDWF (000101dfffff) and SWAPF (001110dfffff) write their result to file register f when d (bit 5) is 1, and to W when d is 0.
- R4: INCF gives f+1 modulo 256. ADDWF gives W+f modulo 256. ANDWF gives W AND f. SWAPF exchanges the two nibbles of f. MOVF passes f unchanged.
- R5: CLRF (0000011fffff) writes 0x00 to file register f. CLRW (000001000000) writes 0x00 to W.
- R6: BTFSC (0110bbbfffff) skips the next word when bit b of f is 0. BTFSS (0111bbbfffff) skips it when that bit is 1. A skip advances the address by 2.
- R7: GOTO (101xkkkkkkkk) and CALL (1001kkkkkkkk) jump to the 8-bit literal. CALL pushes the address after itself. RETLW (1000kkkkkkkk) pops that address into the PC and loads the literal into W. The stack holds two entries: a third nested CALL drops the oldest, and a pop leaves the bottom entry in place.
- R8: TRIS (000000000fff, with fff = 5, 6 or 7) copies W into the direction register of port A, B or C. Direction bit 1 means input, 0 means output. The port's output enable is the inverse of its direction register.
- R9: A read of a port address returns the pin input for bits set as inputs and the output latch for bits set as outputs. The output latch is presented on the port's output vector whatever the direction.
- R10: With no transfer of control, imem_addr advances by one per cycle. A taken skip, GOTO, CALL or RETLW is followed by one dead cycle that holds imem_addr and executes nothing.
- R11: Encodings outside this set, and TRIS with a field other than 5 to 7, change no state. Writes to file addresses 0x00 to 0x04 are dropped, and reads from them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 8 | Program store address (the PC) |
| imem_data | input | 12 | Instruction word at imem_addr, same cycle |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables (1 = driving) |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
The assertions watch control flow on every cycle. A dead cycle must hold the address. A CALL or GOTO must land on its literal. A bit test that skips must advance the address by exactly two. Output enables may change only after an executed TRIS, and an unrecognized word must leave every port latch and enable unchanged. Data results cannot be judged without a reference model: the ALU values, the routing chosen by the destination bit, the pin/latch mix on port reads, and the stack dropping its oldest entry on a third nested call. These are shown only by the bench's programs, which copy each result to a port and compare it with the value the bench computes itself.

// File: rtl/mcu_pkg.sv
package mcu_pkg;

  localparam int DW  = 8;   // data width
  localparam int IW  = 12;  // instruction width
  localparam int PCW = 8;   // program counter width
  localparam int FAW = 5;   // file address width

  typedef enum logic [3:0] {
    OP_NOP, OP_MOVWF, OP_CLRW, OP_CLRF, OP_AND, OP_ADD, OP_MOVF, OP_INC,
    OP_SWAP, OP_BCLR, OP_BSET, OP_RET, OP_CALL, OP_JMP, OP_LIT, OP_DIR
  } op_e;

  typedef struct packed {
    op_e            op;
    logic           to_file;
    logic [FAW-1:0] fsel;
    logic [2:0]     bsel;
    logic [DW-1:0]  lit;
  } dec_t;

endpackage

// File: rtl/mcu_decode.sv
module mcu_decode
  import mcu_pkg::*;
(
  input  logic [IW-1:0] instr,
  output dec_t          dec
);

  always_comb begin
    dec.to_file = instr[5];
    dec.fsel    = instr[FAW-1:0];
    dec.bsel    = instr[7:5];
    dec.lit     = instr[DW-1:0];
    casez (instr)
      12'b0000_0000_0101,
      12'b0000_0000_0110,
      12'b0000_0000_0111: dec.op = OP_DIR;
      12'b0000_001?_????: dec.op = OP_MOVWF;
      12'b0000_0100_0000: dec.op = OP_CLRW;
      12'b0000_011?_????: dec.op = OP_CLRF;
      12'b0001_01??_????: dec.op = OP_AND;
      12'b0001_11??_????: dec.op = OP_ADD;
      12'b0010_00??_????: dec.op = OP_MOVF;
      12'b0010_10??_????: dec.op = OP_INC;
      12'b0011_10??_????: dec.op = OP_SWAP;
      12'b0110_????_????: dec.op = OP_BCLR;
      12'b0111_????_????: dec.op = OP_BSET;
      12'b1000_????_????: dec.op = OP_RET;
      12'b1001_????_????: dec.op = OP_CALL;
      12'b101?_????_????: dec.op = OP_JMP;
      12'b1100_????_????: dec.op = OP_LIT;
      default:            dec.op = OP_NOP;
    endcase
  end

endmodule

// File: rtl/mcu_alu.sv
module mcu_alu
  import mcu_pkg::*;
(
  input  op_e           op,
  input  logic [DW-1:0] w_val,
  input  logic [DW-1:0] f_val,
  input  logic [2:0]    bsel,
  output logic [DW-1:0] result,
  output logic          bit_val
);

  localparam int HALF = DW / 2;

  always_comb begin
    unique case (op)
      OP_AND:   result = w_val & f_val;
      OP_ADD:   result = w_val + f_val;
      OP_INC:   result = f_val + DW'(1);
      OP_SWAP:  result = {f_val[HALF-1:0], f_val[DW-1:HALF]};
      OP_MOVWF: result = w_val;
      OP_MOVF:  result = f_val;
      default:  result = '0;
    endcase
    bit_val = f_val[bsel];
  end

endmodule

// File: rtl/mcu_filemap.sv
module mcu_filemap
  import mcu_pkg::*;
#(
  parameter int NPORT     = 3,
  parameter int PORT_BASE = 5,
  parameter int GPR_BASE  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [FAW-1:0]             wr_addr,
  input  logic [DW-1:0]              wr_data,
  input  logic [FAW-1:0]             rd_addr,
  output logic [DW-1:0]              rd_data,
  input  logic                       dir_en,
  input  logic [FAW-1:0]             dir_sel,
  input  logic [DW-1:0]              dir_data,
  input  logic [NPORT-1:0][DW-1:0]   pin_in,
  output logic [NPORT-1:0][DW-1:0]   pin_out,
  output logic [NPORT-1:0][DW-1:0]   pin_oe
);

  localparam int NGPR = (1 << FAW) - GPR_BASE;
  localparam logic [FAW-1:0] GPR_LO = FAW'(GPR_BASE);

  logic [DW-1:0] gpr_q [NGPR];
  logic [NPORT-1:0][DW-1:0] dir_q;
  logic [NPORT-1:0][DW-1:0] port_rd;

  // general-purpose storage: no reset, software initialises it
  always_ff @(posedge clk) begin
    if (wr_en && wr_addr >= GPR_LO)
      gpr_q[wr_addr - GPR_LO] <= wr_data;
  end

  for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
    localparam logic [FAW-1:0] ADDR = FAW'(PORT_BASE + gi);
    logic lat_we, dir_we;
    assign lat_we = wr_en && (wr_addr == ADDR);
    assign dir_we = dir_en && (dir_sel == ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pin_out[gi] <= '0;
        dir_q[gi]   <= '1;
      end else begin
        if (lat_we) pin_out[gi] <= wr_data;
        if (dir_we) dir_q[gi]   <= dir_data;
      end
    end

    assign pin_oe[gi]  = ~dir_q[gi];
    assign port_rd[gi] = (pin_in[gi] & dir_q[gi]) | (pin_out[gi] & ~dir_q[gi]);
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr >= GPR_LO) rd_data = gpr_q[rd_addr - GPR_LO];
    for (int i = 0; i < NPORT; i++)
      if (rd_addr == FAW'(PORT_BASE + i)) rd_data = port_rd[i];
  end

endmodule

// File: rtl/mcu_core.sv
module mcu_core
  import mcu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  output logic [PCW-1:0] imem_addr,
  input  logic [IW-1:0]  imem_data,
  input  logic [DW-1:0]  pa_in,
  output logic [DW-1:0]  pa_out,
  output logic [DW-1:0]  pa_oe,
  input  logic [DW-1:0]  pb_in,
  output logic [DW-1:0]  pb_out,
  output logic [DW-1:0]  pb_oe,
  input  logic [DW-1:0]  pc_in,
  output logic [DW-1:0]  pc_out,
  output logic [DW-1:0]  pc_oe
);

  localparam int NPORT = 3;

  // reset release synchroniser
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dec_t dec;
  op_e  dec_op;
  logic [DW-1:0] dec_lit;
  logic [DW-1:0] f_rd, alu_res;
  logic          bit_val;

  logic [PCW-1:0] pc_q, pc_d;
  logic           dead_q, dead_d;
  logic [DW-1:0]  w_q, w_d;
  logic           w_we;
  logic [PCW-1:0] stk0_q, stk1_q;
  logic           push, pop;
  logic           f_we, dir_we;

  logic [NPORT-1:0][DW-1:0] port_in_v, port_out_v, port_oe_v;

  mcu_decode u_dec (.instr(imem_data), .dec(dec));
  assign dec_op  = dec.op;
  assign dec_lit = dec.lit;

  mcu_alu u_alu (
    .op(dec.op), .w_val(w_q), .f_val(f_rd), .bsel(dec.bsel),
    .result(alu_res), .bit_val(bit_val)
  );

  assign port_in_v = {pc_in, pb_in, pa_in};

  mcu_filemap #(.NPORT(NPORT), .PORT_BASE(5), .GPR_BASE(8)) u_fm (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(f_we), .wr_addr(dec.fsel), .wr_data(alu_res),
    .rd_addr(dec.fsel), .rd_data(f_rd),
    .dir_en(dir_we), .dir_sel(dec.fsel), .dir_data(w_q),
    .pin_in(port_in_v), .pin_out(port_out_v), .pin_oe(port_oe_v)
  );

  assign {pc_out, pb_out, pa_out} = port_out_v;
  assign {pc_oe,  pb_oe,  pa_oe}  = port_oe_v;
  assign imem_addr = pc_q;

  // next-state logic
  always_comb begin
    pc_d   = pc_q + PCW'(1);
    dead_d = 1'b0;
    w_d    = alu_res;
    w_we   = 1'b0;
    f_we   = 1'b0;
    dir_we = 1'b0;
    push   = 1'b0;
    pop    = 1'b0;
    if (dead_q) begin
      pc_d = pc_q;
    end else begin
      unique case (dec.op)
        OP_MOVWF, OP_CLRF: f_we = 1'b1;
        OP_CLRW:           w_we = 1'b1;
        OP_AND, OP_ADD, OP_MOVF, OP_INC, OP_SWAP: begin
          f_we = dec.to_file;
          w_we = !dec.to_file;
        end
        OP_BCLR, OP_BSET: begin
          if (bit_val == (dec.op == OP_BSET)) begin
            pc_d   = pc_q + PCW'(2);
            dead_d = 1'b1;
          end
        end
        OP_RET: begin
          w_d = dec.lit; w_we = 1'b1;
          pc_d = stk0_q; pop = 1'b1; dead_d = 1'b1;
        end
        OP_CALL: begin
          push = 1'b1; pc_d = dec.lit; dead_d = 1'b1;
        end
        OP_JMP: begin
          pc_d = dec.lit; dead_d = 1'b1;
        end
        OP_LIT: begin
          w_d = dec.lit; w_we = 1'b1;
        end
        OP_DIR:  dir_we = 1'b1;
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q   <= '0;
      dead_q <= 1'b0;
      w_q    <= '0;
      stk0_q <= '0;
      stk1_q <= '0;
    end else begin
      pc_q   <= pc_d;
      dead_q <= dead_d;
      if (w_we) w_q <= w_d;
      if (push) begin
        stk0_q <= pc_q + PCW'(1);
        stk1_q <= stk0_q;
      end else if (pop) begin
        stk0_q <= stk1_q;
      end
    end
  end

endmodule

// File: rtl/mcu_core_chk.sv
module mcu_core_chk
  import mcu_pkg::*;
#(
  parameter int NPORT = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  dead,
  input op_e                   op,
  input logic                  bit_val,
  input logic [DW-1:0]         lit,
  input logic [PCW-1:0]        pc,
  input logic [NPORT*DW-1:0]   oe_all,
  input logic [NPORT*DW-1:0]   out_all
);

  // R10: dead cycle holds the fetch address
  a_r10_dead_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    dead |=> $stable(pc));

  // R7: CALL and GOTO land on their literal
  a_r7_call_target: assert property (@(posedge clk) disable iff (!rst_n)
    (!dead && op == OP_CALL) |=> pc == $past(lit));

  a_r7_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (!dead && op == OP_JMP) |=> pc == $past(lit));

  // R6: a taken bit test advances by two
  a_r6_set_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (!dead && op == OP_BSET && bit_val) |=> pc == $past(pc) + PCW'(2));

  a_r6_clear_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (!dead && op == OP_BCLR && !bit_val) |=> pc == $past(pc) + PCW'(2));

  // R8: enables move only after an executed TRIS
  a_r8_oe_only_by_tris: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_all) |-> $past(!dead && op == OP_DIR));

  // R11: unrecognised words leave the ports untouched
  a_r11_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!dead && op == OP_NOP) |=> ($stable(oe_all) && $stable(out_all)));

endmodule

bind mcu_core mcu_core_chk #(.NPORT(3)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .dead(dead_q), .op(dec_op),
  .bit_val(bit_val), .lit(dec_lit), .pc(pc_q),
  .oe_all(port_oe_v), .out_all(port_out_v)
);

// File: tb/mcu_core_tb_top.sv
module mcu_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  imem_addr;
  logic [11:0] imem_data;
  logic [7:0]  pa_in, pb_in, pc_in;
  logic [7:0]  pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  logic [11:0] rom [256];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  assign imem_data = rom[imem_addr];

  mcu_core dut_i (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 256; i++) rom[i] = 12'h000;
  endtask

  // reset, release, wait through the two synchroniser edges; ends at negedge
  task automatic boot();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [11:0] alu_word(input int k, input logic d, input logic [4:0] f);
    case (k)
      0: return 12'h140 | {6'd0, d, f};
      1: return 12'h1C0 | {6'd0, d, f};
      2: return 12'h200 | {6'd0, d, f};
      3: return 12'h280 | {6'd0, d, f};
      4: return 12'h380 | {6'd0, d, f};
      5: return 12'h060 | {7'd0, f};
      default: return 12'h040;
    endcase
  endfunction

  function automatic logic [7:0] alu_exp(input int k, input logic [7:0] fv, input logic [7:0] wv);
    case (k)
      0: return wv & fv;
      1: return wv + fv;
      2: return fv;
      3: return fv + 8'd1;
      4: return {fv[3:0], fv[7:4]};
      default: return 8'h00;
    endcase
  endfunction

  // load f, load W, op, copy result to port B
  task automatic alu_case(input int k, input logic d, input logic [4:0] f,
                          input logic [7:0] fv, input logic [7:0] wv);
    logic de;
    de = (k == 5) ? 1'b1 : (k == 6) ? 1'b0 : d;
    clear_rom();
    rom[0] = 12'hC00; rom[1] = 12'h006;
    rom[2] = 12'hC00 | fv; rom[3] = 12'h020 | f;
    rom[4] = 12'hC00 | wv; rom[5] = alu_word(k, d, f);
    rom[6] = de ? (12'h200 | f) : 12'h000;
    rom[7] = 12'h026; rom[8] = 12'hA08;
    boot();
    run(12);
    check($sformatf("R3/R4/R5 op%0d d%0d", k, de), pb_out, alu_exp(k, fv, wv));
  endtask

  initial begin
    int timeout_c = 0;
    while (timeout_c < 150000) begin
      @(posedge clk);
      timeout_c++;
    end
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed = 32'h5EED;
    void'($urandom(seed));
    pa_in = 8'h00; pb_in = 8'h00; pc_in = 8'h00;
    rst_n = 1'b0;
    clear_rom();

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 addr", imem_addr, 8'h00);
    check("R1 oe", {pa_oe, pb_oe, pc_oe}, 24'h0);
    check("R1 out", {pa_out, pb_out, pc_out}, 24'h0);

    // R10/R7: fetch timing through GOTO, CALL, RETLW
    clear_rom();
    rom[0] = 12'hA04; rom[5] = 12'h909; rom[9] = 12'h855;
    rom[6] = 12'h0C0;  // harmless unsupported word
    boot();
    check("R1 first fetch", imem_addr, 8'h00);
    begin
      logic [7:0] exp_seq [8] = '{8'h04, 8'h04, 8'h05, 8'h09, 8'h09, 8'h06, 8'h06, 8'h07};
      for (int i = 0; i < 8; i++) begin
        run(1);
        check($sformatf("R10 step %0d", i), imem_addr, exp_seq[i]);
      end
    end

    // R2/R8: direction load and store to port
    clear_rom();
    rom[0] = 12'hC0F; rom[1] = 12'h006; rom[2] = 12'hC96; rom[3] = 12'h026;
    rom[4] = 12'hA04;
    boot();
    run(6);
    check("R8 pb_oe", pb_oe, 8'hF0);
    check("R8 pa_oe untouched", pa_oe, 8'h00);
    check("R2 pb_out", pb_out, 8'h96);

    // R4 corner cases: wrap on increment and add
    alu_case(3, 1'b1, 5'h1F, 8'hFF, 8'h00);
    alu_case(1, 1'b0, 5'h08, 8'hFF, 8'h01);
    alu_case(4, 1'b1, 5'h10, 8'h3C, 8'h00);

    // R3/R4/R5: random ALU cases
    for (int n = 0; n < 40; n++) begin
      alu_case(int'($urandom_range(0, 6)), 1'($urandom), 5'($urandom_range(8, 31)),
               8'($urandom), 8'($urandom));
    end

    // R6: bit test and skip, random
    for (int n = 0; n < 16; n++) begin
      logic [7:0] v;
      logic [2:0] b;
      logic       set_form, skip;
      v = 8'($urandom); b = 3'($urandom); set_form = 1'($urandom);
      skip = set_form ? v[b] : !v[b];
      clear_rom();
      rom[0] = 12'hC00; rom[1] = 12'h006; rom[2] = 12'hC00 | v; rom[3] = 12'h02A;
      rom[4] = 12'hC11;
      rom[5] = (set_form ? 12'h700 : 12'h600) | {4'd0, b, 5'h0A};
      rom[6] = 12'hC22; rom[7] = 12'h026; rom[8] = 12'hA08;
      boot();
      run(12);
      check($sformatf("R6 form%0d bit%0d", set_form, b), pb_out, skip ? 8'h11 : 8'h22);
    end

    // R9: port read mixes pins and latch
    clear_rom();
    rom[0] = 12'hC00; rom[1] = 12'h006; rom[2] = 12'hC0F; rom[3] = 12'h005;
    rom[4] = 12'hCA0; rom[5] = 12'h025; rom[6] = 12'h205; rom[7] = 12'h026;
    rom[8] = 12'hA08;
    pa_in = 8'h3C;
    boot();
    run(12);
    check("R9 read mix", pb_out, 8'hAC);
    check("R9 latch shown", pa_out, 8'hA0);
    check("R8 pa_oe", pa_oe, 8'hF0);
    pa_in = 8'h00;

    // R7: third nested CALL drops the oldest return
    clear_rom();
    rom[0] = 12'hC00; rom[1] = 12'h006; rom[2] = 12'h007; rom[3] = 12'h910;
    rom[4] = 12'hCEE; rom[5] = 12'h026; rom[6] = 12'hA06;
    rom[8'h10] = 12'h920; rom[8'h11] = 12'h027; rom[8'h12] = 12'h803;
    rom[8'h20] = 12'h930; rom[8'h21] = 12'h026; rom[8'h22] = 12'h802;
    rom[8'h30] = 12'h801;
    boot();
    run(40);
    check("R7 inner return value", pb_out, 8'h01);
    check("R7 stack overwrite", pc_out, 8'h03);

    // R11: unsupported words, bad TRIS, low addresses
    clear_rom();
    rom[0] = 12'hC00; rom[1] = 12'h005; rom[2] = 12'h006; rom[3] = 12'h007;
    rom[4] = 12'hC40; rom[5] = 12'h028; rom[6] = 12'hC5A; rom[7] = 12'h023;
    rom[8] = 12'h003; rom[9] = 12'hF5A; rom[10] = 12'h0E8; rom[11] = 12'h026;
    rom[12] = 12'h208; rom[13] = 12'h027; rom[14] = 12'h203; rom[15] = 12'h025;
    rom[16] = 12'hA10;
    boot();
    run(22);
    check("R11 W kept", pb_out, 8'h5A);
    check("R11 reg kept", pc_out, 8'h40);
    check("R11 low addr reads 0", pa_out, 8'h00);
    check("R11 oe kept", {pa_oe, pb_oe, pc_oe}, 24'hFFFFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule